// File: doc/BRIEF.md
# Walking-Ones Memory Bus Tester

This block is a built-in test engine placed ahead of a DRAM cycle sequencer. It checks the wiring of the address and data buses by issuing single transfers with one-hot patterns. Each transfer is a request/acknowledge handshake. A one-cycle trigger pulse marks the first cycle of every generated transfer, so an external probe can sync to it and inspect one line at a time.

A run starts on a start pulse. The address test writes a distinct tag at the all-zero address and then at each one-hot address. It then reads every location back in the same order, so a stuck or shorted address line appears as a wrong tag. The data test walks a single one across the data word at a fixed location, reading each word back before moving on. The first mismatch halts the engine and freezes a failure record. If the run ends cleanly, the block reports a pass.

Top module: `walk_bus_tester`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `done`, `pass`, `bus_req`, `bus_trig` and `fail_phase` are all 0.
- R2: The address test first writes one location per step k = 0..ADDR_BITS. Step k = 0 uses address 0. Step k = b+1 uses the address with only bit b set, for b = 0..ADDR_BITS-1 (bits 0 to 20 by default). The write data is TAG_BASE + k.
- R3: After the writes, the same ADDR_BITS+1 locations are read in the same order. Each read is compared with TAG_BASE + k.
- R4: The data test then handles j = 0..DATA_W-1 in order. For each j it writes the word with only bit j set to address DATA_ADDR, then reads DATA_ADDR back and compares it, before moving to j+1.
- R5: `bus_trig` is high for exactly one cycle, the first cycle in which `bus_req` is high for a transfer.
- R6: `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stay constant until `bus_ack` is sampled high. Read data is taken from `bus_rdata` in that same cycle. Any acknowledge latency is accepted.
- R7: On the first read mismatch, the engine issues no further transfer and sets `done`=1 with `pass`=0. `fail_phase` becomes 1 for the address test or 2 for the data test. `fail_index` becomes k (address test) or j (data test). `fail_exp` and `fail_obs` hold the expected and observed words.
- R8: If all reads match, `done`=1, `pass`=1 and `fail_phase`=0 after exactly 2*(ADDR_BITS+1) + 2*DATA_W transfers.
- R9: A start pulse while a run is in progress is ignored. A start pulse while idle or done clears `done`, `pass` and the failure record in the next cycle and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a run |
| bus_req | output | 1 | Transfer request to the cycle sequencer |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | DATA_W | Write data (0 on reads) |
| bus_trig | output | 1 | Probe trigger, first cycle of each transfer |
| bus_ack | input | 1 | Sequencer has completed the transfer |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| done | output | 1 | Run finished (pass or fail) |
| pass | output | 1 | Run finished with no mismatch |
| fail_phase | output | 2 | 0 none, 1 address test, 2 data test |
| fail_index | output | IDX_W | Failing step k or data bit j |
| fail_exp | output | DATA_W | Expected word at the failure |
| fail_obs | output | DATA_W | Observed word at the failure |

## Verification
The assertions check the bus protocol on every cycle: trigger placement and width, request fields held while waiting, addresses one-hot or zero outside the data location, one-hot data words there, silence after completion, and a consistent failure record. The order of the transfers, the tag values, where a run stops under a given wiring fault, the failure record contents, and the handling of start pulses during a run are shown only by the bench. The bench compares against a reference run of the algorithm over a faulty memory model, with stuck and shorted address lines, stuck data lines and random acknowledge latency.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

  // Test step kinds, in execution order
  typedef enum logic [1:0] {
    PH_AW = 2'd0,   // address test, tag write
    PH_AR = 2'd1,   // address test, tag read
    PH_DW = 2'd2,   // data test, one-hot write
    PH_DR = 2'd3    // data test, read back
  } phase_e;

  // Failure location codes reported on fail_phase
  localparam logic [1:0] FC_NONE = 2'd0;
  localparam logic [1:0] FC_ADDR = 2'd1;
  localparam logic [1:0] FC_DATA = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } state_e;

endpackage

// File: rtl/wbt_pattern.sv
module wbt_pattern #(
  parameter int          ADDR_W    = 22,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_BITS = 21,
  parameter int          IDX_W     = 6,
  parameter logic [31:0] TAG_BASE  = 32'hA5A5_0000,
  parameter logic [31:0] DATA_ADDR = 32'h0000_0155
) (
  input  wbt_pkg::phase_e    phase,
  input  logic [IDX_W-1:0]   idx,
  output logic [ADDR_W-1:0]  addr,
  output logic               we,
  output logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  expv,
  output logic               last
);
  import wbt_pkg::*;

  localparam logic [IDX_W-1:0]  LAST_A   = IDX_W'(ADDR_BITS);
  localparam logic [IDX_W-1:0]  LAST_D   = IDX_W'(DATA_W - 1);
  localparam logic [ADDR_W-1:0] FIX_ADDR = ADDR_W'(DATA_ADDR);
  localparam logic [DATA_W-1:0] TAG0     = DATA_W'(TAG_BASE);

  logic [ADDR_W-1:0] walk_addr;
  logic [DATA_W-1:0] walk_data;
  logic [DATA_W-1:0] tag;

  // step k = b+1 selects address bit b; step 0 leaves all bits low
  for (genvar b = 0; b < ADDR_W; b++) begin : g_addr
    if (b < ADDR_BITS) begin : g_walk
      assign walk_addr[b] = (idx == IDX_W'(b + 1));
    end else begin : g_zero
      assign walk_addr[b] = 1'b0;
    end
  end

  for (genvar j = 0; j < DATA_W; j++) begin : g_data
    assign walk_data[j] = (idx == IDX_W'(j));
  end

  assign tag = TAG0 + DATA_W'(idx);

  always_comb begin
    addr  = walk_addr;
    we    = 1'b0;
    wdata = '0;
    expv  = tag;
    last  = (idx == LAST_A);
    unique case (phase)
      PH_AW: begin
        we    = 1'b1;
        wdata = tag;
      end
      PH_AR: begin
        we    = 1'b0;
      end
      PH_DW: begin
        addr  = FIX_ADDR;
        we    = 1'b1;
        wdata = walk_data;
        expv  = walk_data;
        last  = (idx == LAST_D);
      end
      default: begin
        addr  = FIX_ADDR;
        expv  = walk_data;
        last  = (idx == LAST_D);
      end
    endcase
  end

endmodule

// File: rtl/wbt_busport.sv
module wbt_busport #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ack,
  input  logic [DATA_W-1:0] rdata,
  output logic              req,
  output logic              req_we,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  output logic              trig,
  output logic              fin,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req       <= 1'b0;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      trig      <= 1'b0;
      fin       <= 1'b0;
      rdata_q   <= '0;
    end else begin
      trig <= 1'b0;
      fin  <= 1'b0;
      if (go) begin
        req       <= 1'b1;
        trig      <= 1'b1;
        req_we    <= we;
        req_addr  <= addr;
        req_wdata <= wdata;
      end else if (req && ack) begin
        req     <= 1'b0;
        fin     <= 1'b1;
        rdata_q <= rdata;
      end
    end
  end

endmodule

// File: rtl/wbt_judge.sv
module wbt_judge #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              chk,
  input  logic              ok_end,
  input  wbt_pkg::phase_e   phase,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] expv,
  input  logic [DATA_W-1:0] obs,
  output logic              mism,
  output logic              done,
  output logic              pass,
  output logic [1:0]        fail_code,
  output logic [IDX_W-1:0]  fail_idx,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_obs
);
  import wbt_pkg::*;

  assign mism = (expv != obs);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      done      <= 1'b0;
      pass      <= 1'b0;
      fail_code <= FC_NONE;
      fail_idx  <= '0;
      fail_exp  <= '0;
      fail_obs  <= '0;
    end else if (chk && mism) begin
      done      <= 1'b1;
      pass      <= 1'b0;
      fail_code <= (phase == PH_AR) ? FC_ADDR : FC_DATA;
      fail_idx  <= idx;
      fail_exp  <= expv;
      fail_obs  <= obs;
    end else if (ok_end) begin
      done <= 1'b1;
      pass <= 1'b1;
    end
  end

endmodule

// File: rtl/walk_bus_tester.sv
module walk_bus_tester #(
  parameter int          ADDR_W    = 22,
  parameter int          DATA_W    = 32,
  parameter int          ADDR_BITS = 21,
  parameter logic [31:0] TAG_BASE  = 32'hA5A5_0000,
  parameter logic [31:0] DATA_ADDR = 32'h0000_0155,
  localparam int         MAXN      = (ADDR_BITS + 1 > DATA_W) ? ADDR_BITS + 1 : DATA_W,
  localparam int         IDX_W     = $clog2(MAXN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_trig,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              done,
  output logic              pass,
  output logic [1:0]        fail_phase,
  output logic [IDX_W-1:0]  fail_index,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_obs
);
  import wbt_pkg::*;

  state_e            state;
  phase_e            phase;
  logic [IDX_W-1:0]  idx;

  logic [ADDR_W-1:0] pat_addr;
  logic              pat_we;
  logic [DATA_W-1:0] pat_wdata;
  logic [DATA_W-1:0] pat_exp;
  logic              pat_last;

  logic              go;
  logic              fin;
  logic [DATA_W-1:0] rd_q;
  logic              mism;
  logic              idle_like;
  logic              clr;
  logic              chk;
  logic              ok_end;

  assign idle_like = (state == ST_IDLE) || (state == ST_DONE);
  assign clr       = idle_like && start;
  assign go        = (state == ST_LAUNCH);
  assign chk       = (state == ST_WAIT) && fin && !pat_we;
  assign ok_end    = chk && !mism && (phase == PH_DR) && pat_last;

  wbt_pattern #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_BITS(ADDR_BITS),
    .IDX_W(IDX_W), .TAG_BASE(TAG_BASE), .DATA_ADDR(DATA_ADDR)
  ) u_pat (
    .phase (phase),
    .idx   (idx),
    .addr  (pat_addr),
    .we    (pat_we),
    .wdata (pat_wdata),
    .expv  (pat_exp),
    .last  (pat_last)
  );

  wbt_busport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .we        (pat_we),
    .addr      (pat_addr),
    .wdata     (pat_wdata),
    .ack       (bus_ack),
    .rdata     (bus_rdata),
    .req       (bus_req),
    .req_we    (bus_we),
    .req_addr  (bus_addr),
    .req_wdata (bus_wdata),
    .trig      (bus_trig),
    .fin       (fin),
    .rdata_q   (rd_q)
  );

  wbt_judge #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_judge (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .chk       (chk),
    .ok_end    (ok_end),
    .phase     (phase),
    .idx       (idx),
    .expv      (pat_exp),
    .obs       (rd_q),
    .mism      (mism),
    .done      (done),
    .pass      (pass),
    .fail_code (fail_phase),
    .fail_idx  (fail_index),
    .fail_exp  (fail_exp),
    .fail_obs  (fail_obs)
  );

  // Step sequencer: one transfer in flight at a time
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      phase <= PH_AW;
      idx   <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            phase <= PH_AW;
            idx   <= '0;
            state <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state <= ST_WAIT;
        default: begin
          if (fin) begin
            if (chk && mism) begin
              state <= ST_DONE;
            end else if (ok_end) begin
              state <= ST_DONE;
            end else begin
              state <= ST_LAUNCH;
              unique case (phase)
                PH_AW: begin
                  if (pat_last) begin
                    phase <= PH_AR;
                    idx   <= '0;
                  end else begin
                    idx <= idx + IDX_W'(1);
                  end
                end
                PH_AR: begin
                  if (pat_last) begin
                    phase <= PH_DW;
                    idx   <= '0;
                  end else begin
                    idx <= idx + IDX_W'(1);
                  end
                end
                PH_DW: phase <= PH_DR;
                default: begin
                  phase <= PH_DW;
                  idx   <= idx + IDX_W'(1);
                end
              endcase
            end
          end
        end
      endcase
    end
  end

endmodule

module wbt_checker #(
  parameter int          ADDR_W    = 22,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] DATA_ADDR = 32'h0000_0155
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_trig,
  input logic              bus_ack,
  input logic              done,
  input logic              pass,
  input logic [1:0]        fail_phase,
  input logic [DATA_W-1:0] fail_exp,
  input logic [DATA_W-1:0] fail_obs
);
  localparam logic [ADDR_W-1:0] FIX_ADDR = ADDR_W'(DATA_ADDR);

  // R5
  trig_in_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_trig |-> bus_req);

  // R5
  trig_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> bus_trig);

  // R5
  trig_single_chk: assert property (@(posedge clk) disable iff (rst)
    bus_trig |=> !bus_trig);

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) &&
                              $stable(bus_addr) && $stable(bus_wdata)));

  // R2
  addr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_addr != FIX_ADDR) |-> ($countones(bus_addr) <= 1));

  // R4
  data_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && bus_addr == FIX_ADDR) |-> ($countones(bus_wdata) == 1));

  // R7
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_req);

  // R7
  fail_record_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !pass) |-> (fail_phase != 2'd0 && fail_exp != fail_obs));

  // R8
  pass_clean_chk: assert property (@(posedge clk) disable iff (rst)
    pass |-> (done && fail_phase == 2'd0));

endmodule

bind walk_bus_tester wbt_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_ADDR(DATA_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_trig   (bus_trig),
  .bus_ack    (bus_ack),
  .done       (done),
  .pass       (pass),
  .fail_phase (fail_phase),
  .fail_exp   (fail_exp),
  .fail_obs   (fail_obs)
);

// File: tb/walk_bus_tester_test.sv
module walk_bus_tester_test;
  localparam int          CLK_PERIOD = 10;
  localparam int          ADDR_W     = 22;
  localparam int          DATA_W     = 32;
  localparam int          ADDR_BITS  = 21;
  localparam int          IDX_W      = 6;
  localparam logic [31:0] TAG_BASE   = 32'hA5A5_0000;
  localparam logic [31:0] DATA_ADDR  = 32'h0000_0155;
  localparam int          RUN_LIMIT  = 6000;
  localparam int          MAXS       = 128;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              bus_req, bus_we, bus_trig;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_ack = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic              done, pass;
  logic [1:0]        fail_phase;
  logic [IDX_W-1:0]  fail_index;
  logic [DATA_W-1:0] fail_exp, fail_obs;

  walk_bus_tester #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_BITS(ADDR_BITS),
    .TAG_BASE(TAG_BASE), .DATA_ADDR(DATA_ADDR)
  ) uut (
    .clk(clk), .rst(rst), .start(start),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_trig(bus_trig),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .done(done), .pass(pass), .fail_phase(fail_phase),
    .fail_index(fail_index), .fail_exp(fail_exp), .fail_obs(fail_obs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // fault model: 0 none, 1 addr bit fa stuck low, 2 addr bits fa/fb shorted,
  // 3 data bit fa reads low, 4 data bit fa reads high
  int f_kind = 0;
  int f_a = 0;
  int f_b = 0;

  logic [DATA_W-1:0] dev_mem [int];
  logic [DATA_W-1:0] mdl_mem [int];

  // expected transfer list and outcome
  logic [ADDR_W-1:0] m_addr [MAXS];
  logic              m_we   [MAXS];
  logic [DATA_W-1:0] m_wd   [MAXS];
  int                m_n;
  logic              m_pass;
  logic [1:0]        m_code;
  int                m_idx;
  logic [DATA_W-1:0] m_exp, m_obs;

  int step_n = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] phys(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] p = a;
    if (f_kind == 1) p[f_a] = 1'b0;
    if (f_kind == 2 && (a[f_a] || a[f_b])) begin
      p[f_a] = 1'b1;
      p[f_b] = 1'b1;
    end
    return p;
  endfunction

  function automatic logic [DATA_W-1:0] rd_fault(input logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] r = d;
    if (f_kind == 3) r[f_a] = 1'b0;
    if (f_kind == 4) r[f_a] = 1'b1;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] walk_addr(input int k);
    return (k == 0) ? '0 : (ADDR_W'(1) << (k - 1));
  endfunction

  function automatic logic [DATA_W-1:0] mdl_read(input logic [ADDR_W-1:0] a);
    int p = int'(phys(a));
    return rd_fault(mdl_mem.exists(p) ? mdl_mem[p] : '0);
  endfunction

  function automatic void push(input logic [ADDR_W-1:0] a, input logic w,
                               input logic [DATA_W-1:0] d);
    m_addr[m_n] = a;
    m_we[m_n]   = w;
    m_wd[m_n]   = w ? d : '0;
    m_n++;
    if (w) mdl_mem[int'(phys(a))] = d;
  endfunction

  // Reference run of the test algorithm over the faulty memory (R2 R3 R4 R7 R8)
  function automatic void build_model();
    logic [DATA_W-1:0] o;
    logic [DATA_W-1:0] e;
    mdl_mem.delete();
    m_n = 0; m_pass = 1'b1; m_code = 2'd0; m_idx = 0; m_exp = '0; m_obs = '0;
    for (int k = 0; k <= ADDR_BITS; k++)
      push(walk_addr(k), 1'b1, TAG_BASE + DATA_W'(k));
    for (int k = 0; k <= ADDR_BITS; k++) begin
      push(walk_addr(k), 1'b0, '0);
      o = mdl_read(walk_addr(k));
      e = TAG_BASE + DATA_W'(k);
      if (o != e) begin
        m_pass = 1'b0; m_code = 2'd1; m_idx = k; m_exp = e; m_obs = o;
        return;
      end
    end
    for (int j = 0; j < DATA_W; j++) begin
      e = DATA_W'(1) << j;
      push(ADDR_W'(DATA_ADDR), 1'b1, e);
      push(ADDR_W'(DATA_ADDR), 1'b0, '0);
      o = mdl_read(ADDR_W'(DATA_ADDR));
      if (o != e) begin
        m_pass = 1'b0; m_code = 2'd2; m_idx = j; m_exp = e; m_obs = o;
        return;
      end
    end
  endfunction

  // Sequencer model: random acknowledge latency
  initial begin
    int wait_cnt = 0;
    int p;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
      end else if (bus_req) begin
        if (wait_cnt == 0) begin
          p = int'(phys(bus_addr));
          if (bus_we) dev_mem[p] = bus_wdata;
          else bus_rdata = rd_fault(dev_mem.exists(p) ? dev_mem[p] : '0);
          bus_ack  = 1'b1;
          wait_cnt = $urandom_range(0, 3);
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  // Transfer monitor: order, fields, trigger shape, field hold
  initial begin
    logic              prev_trig = 1'b0;
    logic [ADDR_W-1:0] h_addr = '0;
    logic              h_we = 1'b0;
    logic [DATA_W-1:0] h_wd = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (bus_trig) begin
          check("R5", "trigger without request", bus_req, 1'b1);
          check("R5", "trigger longer than one cycle", prev_trig, 1'b0);
          if (step_n < m_n) begin
            check("R2 R3 R4", "transfer address", bus_addr, m_addr[step_n]);
            check("R2 R3 R4", "transfer direction", bus_we, m_we[step_n]);
            check("R2 R4", "transfer write data", bus_wdata, m_wd[step_n]);
          end else begin
            check("R7", "transfer beyond expected count", step_n, m_n - 1);
          end
          step_n++;
          h_addr = bus_addr; h_we = bus_we; h_wd = bus_wdata;
        end else if (bus_req) begin
          check("R6", "request fields held", {bus_we, bus_addr, bus_wdata},
                {h_we, h_addr, h_wd});
        end
        prev_trig = bus_trig;
      end
    end
  end

  task automatic run_test(input int extra_at, input string label);
    int c;
    build_model();
    dev_mem.delete();
    step_n = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9", {label, " done cleared by start"}, done, 1'b0);
    check("R9", {label, " fail_phase cleared by start"}, fail_phase, 2'd0);
    c = 1;
    while (!done && c < RUN_LIMIT) begin
      @(negedge clk);
      c++;
      start = (c == extra_at);
    end
    start = 1'b0;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R8 %s watchdog: actual done=0 expected done=1", label);
    end else begin
      repeat (6) @(negedge clk);
      check("R7 R8", {label, " done"}, done, 1'b1);
      check("R7 R8", {label, " pass"}, pass, m_pass);
      check("R7 R8", {label, " transfer count"}, step_n, m_n);
      check("R7", {label, " fail_phase"}, fail_phase, m_code);
      if (!m_pass) begin
        check("R7", {label, " fail_index"}, fail_index, m_idx);
        check("R7", {label, " fail_exp"}, fail_exp, m_exp);
        check("R7", {label, " fail_obs"}, fail_obs, m_obs);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    m_n = 0;
    repeat (3) @(negedge clk);
    check("R1", "done in reset", done, 1'b0);
    check("R1", "req in reset", bus_req, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "done after reset", done, 1'b0);
    check("R1", "pass after reset", pass, 1'b0);
    check("R1", "req after reset", bus_req, 1'b0);
    check("R1", "trig after reset", bus_trig, 1'b0);
    check("R1", "fail_phase after reset", fail_phase, 2'd0);

    // clean wiring, stray start in mid-run (R8 R9)
    f_kind = 0;
    run_test(40, "clean+stray start");
    check("R8", "clean run total", m_n, 2 * (ADDR_BITS + 1) + 2 * DATA_W);

    // directed wiring faults (R7)
    f_kind = 1; f_a = 0;  run_test(0, "addr bit0 stuck low");
    f_kind = 1; f_a = 20; run_test(0, "addr bit20 stuck low");
    f_kind = 2; f_a = 3; f_b = 4; run_test(0, "addr bits 3/4 shorted");
    f_kind = 3; f_a = 10; run_test(0, "data bit10 low");
    check("R4", "data fault found in data test", m_code, 2'd2);
    f_kind = 4; f_a = 31; run_test(0, "data bit31 high");
    f_kind = 3; f_a = DATA_W - 1; run_test(0, "data top bit low");

    // restart after a failure clears status (R9)
    f_kind = 0;
    run_test(0, "restart clean");

    // random faults
    for (int i = 0; i < 8; i++) begin
      f_kind = $urandom_range(1, 4);
      if (f_kind <= 2) begin
        f_a = $urandom_range(0, ADDR_BITS - 1);
        f_b = (f_a + 1 + $urandom_range(0, ADDR_BITS - 2)) % ADDR_BITS;
      end else begin
        f_a = $urandom_range(0, DATA_W - 1);
      end
      run_test(0, "random fault");
    end

    f_kind = 0;
    run_test(0, "final clean");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule